// File: doc/BRIEF.md
# SMBus Target Front End with Strap Address and Alert Response

This block is the serial-bus face of a small 8-bit port expander. It oversamples the host's clock and data lines on the system clock and finds start, stop and repeated-start conditions. It then shifts in the address byte and compares it with its own 7-bit address. When the address matches, the block acknowledges the transfer and moves register bytes between the bus and a simple internal read/write port. The data line is never driven high. The block only asserts a pull-low enable, and an external resistor provides the high level. The host supplies the clock for every bit in both directions.

The low three bits of the target address come from strap pins. These pins are captured once, just after power-on reset, and later changes on them have no effect. The block also keeps an active-low alert output. When that alert is pending, the block accepts a read to the shared alert-response address and returns its own address, which tells the host which target raised the alert. The alert is then withdrawn.

In a write, the first data byte selects the register and any later bytes are stored there. A read returns the selected register, and the pointer is kept across a repeated start.

Top module: `smbt_target`

## Requirements
- R1: The target address is 0x20 plus the strap value, so binary 0100 followed by strap bits 2..0. An address byte (address in bits 7:1, read flag in bit 0, 1 = read) that carries this address is acknowledged by pulling SDA low during the ninth clock.
- R2: The straps are captured on the first clock after reset is released. Strap changes after that point do not change the address that is acknowledged until the next reset.
- R3: An address byte that selects neither this target nor an alert-response read that the target may accept is not acknowledged. SDA stays released, and every clock edge is ignored until the next START.
- R4: In a write, the first data byte is acknowledged and its low PTR_W bits become the register pointer, which appears on `reg_ptr`.
- R5: Each later write byte is acknowledged and produces exactly one single-cycle `reg_we` pulse, with that byte on `reg_wdata` and the pointer unchanged.
- R6: In a read, the block sends `reg_rdata` at the pointer, most significant bit first. It sends another byte when the host acknowledges and stops sending when the host does not.
- R7: While the alert is pending, a read addressed to 0001100 (byte 0x19) is acknowledged and returns the own address in bits 7:1 with bit 0 at 0.
- R8: `alert_n` is high after reset and goes low one cycle after `alert_set`. It returns high only after the host has clocked the acknowledge bit that follows an alert-response data byte.
- R9: SDA is controlled only through the pull-low enable `sda_pull`. That enable changes only while SCL is low, except that it is released when a START or STOP is seen.
- R10: A STOP returns the block to idle, so bytes clocked afterwards without a START get no acknowledge and cause no write. A repeated START begins a new address phase and keeps the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-on reset |
| strap_in | input | 3 | Address strap pins that set the low address bits |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_pull | output | 1 | When 1, the pad pulls SDA low; when 0, it releases the line |
| alert_set | input | 1 | Single-cycle request from the expander core to raise the alert |
| alert_n | output | 1 | Active-low alert line |
| reg_ptr | output | PTR_W | Currently selected register |
| reg_wdata | output | 8 | Byte to store at `reg_ptr` |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_ptr` |

## Verification
Several properties are checked on every cycle. Once captured, the strap register never changes. `sda_pull` changes only while the synchronised SCL is low, or at a START or STOP. The data line is always released in the idle state. A write strobe never lasts more than one cycle. The alert rises only after an alert-response byte completes. Address decoding, acknowledge timing, the byte order of reads, the pointer's survival across a repeated start, and the alert-response payload need whole bus transactions. The bench shows these by sweeping every strap value and every 7-bit address.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  localparam int STRAP_W = 3;
  localparam int ADDR_W  = 7;

  localparam logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 4'b0100;
  localparam logic [ADDR_W-1:0]         ARA_ADDR    = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_HACK
  } smbt_state_e;

  function automatic logic [ADDR_W-1:0] own_addr_f(input logic [STRAP_W-1:0] strap);
    return {ADDR_PREFIX, strap};
  endfunction

  function automatic logic [7:0] ara_payload_f(input logic [ADDR_W-1:0] addr);
    return {addr, 1'b0};
  endfunction

endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smbt_strap.sv
module smbt_strap
  import smbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [ADDR_W-1:0]  own_addr
);

  logic               sampled;
  logic [STRAP_W-1:0] strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled <= 1'b0;
      strap_q <= '0;
    end else if (!sampled) begin
      sampled <= 1'b1;
      strap_q <= strap_in;
    end
  end

  assign own_addr = own_addr_f(strap_q);

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    sampled |=> $stable(strap_q)); // R2

endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
  import smbt_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              alert_pend,
  input  logic [7:0]        reg_rdata,
  output logic              sda_pull,
  output logic [PTR_W-1:0]  reg_ptr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  output logic              ara_done
);

  localparam int          CNT_W    = $clog2(8);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(7);

  smbt_state_e      state;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg, txreg;
  logic             is_read, is_ara, ptr_phase, ack_drv;

  logic [7:0] rx_next, tx_load;
  logic       hit_own, hit_ara;

  assign rx_next = {shreg[6:0], sda_s};
  assign hit_own = (rx_next[7:1] == own_addr);
  assign hit_ara = (rx_next[7:1] == ARA_ADDR) && rx_next[0] && alert_pend;
  assign tx_load = is_ara ? ara_payload_f(own_addr) : reg_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      txreg     <= '0;
      is_read   <= 1'b0;
      is_ara    <= 1'b0;
      ptr_phase <= 1'b0;
      ack_drv   <= 1'b0;
      sda_pull  <= 1'b0;
      reg_ptr   <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      ara_done  <= 1'b0;
    end else begin
      reg_we   <= 1'b0;
      ara_done <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        ack_drv  <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (hit_own || hit_ara) begin
                state     <= ST_ACK;
                ack_drv   <= 1'b0;
                is_read   <= rx_next[0];
                is_ara    <= hit_ara;
                ptr_phase <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_drv) begin
              sda_pull <= 1'b1;
              ack_drv  <= 1'b1;
            end else begin
              ack_drv <= 1'b0;
              bit_cnt <= '0;
              if (is_read) begin
                sda_pull <= ~tx_load[7];
                txreg    <= {tx_load[6:0], 1'b0};
                state    <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            shreg   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              state   <= ST_ACK;
              ack_drv <= 1'b0;
              if (ptr_phase) begin
                reg_ptr   <= rx_next[PTR_W-1:0];
                ptr_phase <= 1'b0;
              end else begin
                reg_we    <= 1'b1;
                reg_wdata <= rx_next;
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              sda_pull <= ~txreg[7];
              txreg    <= {txreg[6:0], 1'b0};
            end
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) state <= ST_HACK;
            end
          end
          ST_HACK: begin
            if (scl_fall) begin
              if (ack_drv) begin
                ack_drv  <= 1'b0;
                bit_cnt  <= '0;
                sda_pull <= ~tx_load[7];
                txreg    <= {tx_load[6:0], 1'b0};
                state    <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
              end
            end
            if (scl_rise) begin
              if (is_ara) ara_done <= 1'b1;
              if (sda_s) state   <= ST_IDLE;
              else       ack_drv <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) || $fell(sda_pull)) |-> (!scl_s || $past(start_det) || $past(stop_det))); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull); // R3

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R5

endmodule

// File: rtl/smbt_target.sv
module smbt_target
  import smbt_pkg::*;
#(
  parameter int PTR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic               alert_set,
  output logic               alert_n,
  output logic [PTR_W-1:0]   reg_ptr,
  output logic [7:0]         reg_wdata,
  output logic               reg_we,
  input  logic [7:0]         reg_rdata
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;
  logic              alert_pend, ara_done;

  smbt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbt_strap strap_i (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .own_addr(own_addr)
  );

  smbt_engine #(.PTR_W(PTR_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .alert_pend(alert_pend), .reg_rdata(reg_rdata),
    .sda_pull(sda_pull), .reg_ptr(reg_ptr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .ara_done(ara_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alert_pend <= 1'b0;
    else if (alert_set) alert_pend <= 1'b1;
    else if (ara_done)  alert_pend <= 1'b0;
  end

  assign alert_n = ~alert_pend;

  AST_ALERT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_n) |-> $past(ara_done)); // R8

endmodule

// File: tb/smbt_target_tb_top.sv
module smbt_target_tb_top;

  localparam int PTR_W = 3;
  localparam int Q     = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, scl_m, sda_m, alert_set;
  logic [2:0]       strap;
  wire              sda_pull, alert_n, reg_we;
  wire  [PTR_W-1:0] reg_ptr;
  wire  [7:0]       reg_wdata;
  logic [7:0]       regs [0:(1<<PTR_W)-1];
  wire  [7:0]       reg_rdata = regs[reg_ptr];
  wire              bus_sda   = sda_m & ~sda_pull;

  smbt_target #(.PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_in(strap), .scl_in(scl_m), .sda_in(bus_sda),
    .sda_pull(sda_pull), .alert_set(alert_set), .alert_n(alert_n),
    .reg_ptr(reg_ptr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  int we_cnt = 0;
  int viol   = 0;
  always @(posedge clk) begin
    if (reg_we) begin
      regs[reg_ptr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  logic prev_pull = 1'b0;
  always @(posedge clk) begin
    if (rst_n && (sda_pull !== prev_pull) && scl_m) viol <= viol + 1;
    prev_pull <= sda_pull;
  end

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] s);
    rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m = 1'b1; alert_set = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = bus_sda;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic more, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~more);
  endtask

  function automatic int exp_addr(input int s);
    return 32 + s;
  endfunction

  initial begin
    logic       ack;
    logic [7:0] rd, dat;
    int         w0;
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      chk("R8 reset alert_n", int'(alert_n), 1);
      chk("R9 reset sda_pull", int'(sda_pull), 0);
      chk("R5 reset reg_we", int'(reg_we), 0);
      strap = ~3'(s);
      dat = 8'(8'h5A ^ (s * 37));
      w0 = we_cnt;
      bstart();
      wbyte(8'(exp_addr(s) * 2), ack);     chk("R1 own write ack", int'(ack), 1);
      wbyte(8'(8'hF8 | s), ack);           chk("R4 pointer ack", int'(ack), 1);
      chk("R4 pointer value", int'(reg_ptr), s);
      wbyte(dat, ack);                     chk("R5 data ack", int'(ack), 1);
      bstop();
      chk("R5 one strobe", we_cnt - w0, 1);
      chk("R5 stored byte", int'(regs[s]), int'(dat));
      chk("R5 pointer kept", int'(reg_ptr), s);
      bstart();
      wbyte(8'(exp_addr(7 - s) * 2), ack); chk("R2 later strap ignored", int'(ack), 0);
      bstop();
      bstart();
      wbyte(8'(exp_addr(s) * 2), ack);
      wbyte(8'(s), ack);
      bstart();
      wbyte(8'(exp_addr(s) * 2 + 1), ack); chk("R10 repeated start read ack", int'(ack), 1);
      rbyte(1'b1, rd);                     chk("R6 read byte 1", int'(rd), int'(dat));
      rbyte(1'b0, rd);                     chk("R6 read byte 2", int'(rd), int'(dat));
      bstop();
    end

    do_reset(3'd5);
    for (int a = 0; a < 128; a++) begin
      bstart();
      wbyte(8'(a * 2), ack);
      bstop();
      chk("R1 R3 address sweep", int'(ack), (a == exp_addr(5)) ? 1 : 0);
    end

    bstart();
    wbyte(8'h00, ack);                     chk("R3 foreign nack", int'(ack), 0);
    wbyte(8'(exp_addr(5) * 2), ack);       chk("R3 ignored until start", int'(ack), 0);
    bstop();

    bstart();
    wbyte(8'h19, ack);                     chk("R3 R7 alert read without alert", int'(ack), 0);
    bstop();

    @(negedge clk) alert_set = 1'b1;
    @(negedge clk) alert_set = 1'b0;
    chk("R8 alert asserted", int'(alert_n), 0);
    bstart();
    wbyte(8'h19, ack);                     chk("R7 alert read ack", int'(ack), 1);
    rbyte(1'b0, rd);                       chk("R7 alert payload", int'(rd), exp_addr(5) * 2);
    bstop();
    chk("R8 alert released", int'(alert_n), 1);
    bstart();
    wbyte(8'h19, ack);                     chk("R8 no second alert reply", int'(ack), 0);
    bstop();

    w0 = we_cnt;
    bstart();
    wbyte(8'(exp_addr(5) * 2), ack);
    wbyte(8'h02, ack);
    wbyte(8'h33, ack);
    bstop();
    scl_m = 1'b0; tick(Q);
    wbyte(8'h44, ack);                     chk("R10 bytes after stop nack", int'(ack), 0);
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    chk("R10 no write after stop", we_cnt - w0, 1);
    chk("R10 stored before stop", int'(regs[2]), 8'h33);

    chk("R9 pull changes only with SCL low", viol, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule